// File: doc/BRIEF.md
# Fan Drive Value Sequencer

This block turns a requested fan speed code into the code that feeds a fan drive DAC. A fan that is asked to spin from rest first receives a boost level for a programmable number of timing ticks, so that it is sure to start. After that the drive follows the request, held between a minimum level that keeps the fan turning and a maximum level that keeps it below full scale.

A separate enable output tells an external switching or DC-DC fan controller when to run. It drops, and the drive code goes to zero, as soon as the request is zero or falls below the minimum level. All outputs are registered: any change on the inputs shows at the outputs one clock later, and the bounds are evaluated again on every cycle.

Top module: `fan_drive_seq`

## Requirements
- R1: During and directly after reset, `drive` is 0 and `fan_on` is 0.
- R2: A request counts as active when `req_lvl` is nonzero and `req_lvl >= min_lvl`; on any clock edge where it is not active, the next `drive` is 0 and the next `fan_on` is 0, whatever the current phase.
- R3: When the block is idle and the request becomes active, on the next clock edge `fan_on` goes to 1 and `drive` takes the boost level.
- R4: The boost level is held while a tick counter, cleared on entry, stays below `boost_ticks`; `tick` adds one per clock edge while in boost; on the first edge where the count is at least `boost_ticks`, the drive switches to the run level (with `boost_ticks` = 0 this is the edge after entry).
- R5: In the run phase `drive` equals `req_lvl` when it lies within `[min_lvl, max_lvl]`, and `max_lvl` when the request is above `max_lvl`; while `fan_on` is 1, `drive` never exceeds the `max_lvl` of the previous edge.
- R6: When `min_lvl` is above `max_lvl`, the maximum wins and the run drive equals `max_lvl`.
- R7: The boost level is `start_lvl`, reduced to `max_lvl` when `start_lvl` exceeds it.
- R8: Changes of `req_lvl`, `start_lvl`, `min_lvl` and `max_lvl` are applied at the very next clock edge in boost and run phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_lvl | input | DW | Requested drive code |
| start_lvl | input | DW | Boost level used while starting |
| min_lvl | input | DW | Lowest running drive code |
| max_lvl | input | DW | Highest drive code |
| boost_ticks | input | TW | Number of ticks the boost lasts |
| tick | input | 1 | Boost timing tick, one clock wide |
| drive | output | DW | Final drive code |
| fan_on | output | 1 | Enable for an external fan controller |

## Verification
The assertions take for granted that the level inputs are stable across each clock edge and that `tick` is a synchronous single-cycle strobe; they do not assume `min_lvl <= max_lvl` or `start_lvl <= max_lvl`. The stimulus changes inputs only on the falling edge, draws requests mostly above the minimum so the boost and run phases are reached often, and deliberately draws crossed bounds, zero requests and zero boost lengths.

// File: rtl/fan_drive_seq.sv
module fan_drive_seq #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] req_lvl,
  input  logic [DW-1:0] start_lvl,
  input  logic [DW-1:0] min_lvl,
  input  logic [DW-1:0] max_lvl,
  input  logic [TW-1:0] boost_ticks,
  input  logic          tick,
  output logic [DW-1:0] drive,
  output logic          fan_on
);

  typedef enum logic [1:0] {S_OFF, S_BOOST, S_RUN} st_t;

  st_t st;
  logic [TW-1:0] cnt;
  logic active;
  logic [DW-1:0] boost_val, lo_bound, run_val;

  assign active    = (req_lvl != '0) && (req_lvl >= min_lvl);
  assign boost_val = (start_lvl > max_lvl) ? max_lvl : start_lvl;
  assign lo_bound  = (req_lvl < min_lvl) ? min_lvl : req_lvl;
  assign run_val   = (lo_bound > max_lvl) ? max_lvl : lo_bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      drive  <= '0;
      fan_on <= 1'b0;
    end else if (!active) begin
      st     <= S_OFF;
      cnt    <= '0;
      drive  <= '0;
      fan_on <= 1'b0;
    end else begin
      fan_on <= 1'b1;
      case (st)
        S_OFF: begin
          st    <= S_BOOST;
          cnt   <= '0;
          drive <= boost_val;
        end
        S_BOOST: begin
          if (cnt >= boost_ticks) begin
            st    <= S_RUN;
            drive <= run_val;
          end else begin
            drive <= boost_val;
            if (tick) cnt <= cnt + 1'b1;
          end
        end
        default: drive <= run_val;
      endcase
    end
  end

  assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fan_on |-> drive == '0);

  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(req_lvl) != '0) && ($past(req_lvl) >= $past(min_lvl))) |-> !fan_on);

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fan_on |-> drive <= $past(max_lvl));

  assert_boost_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fan_on) |-> drive == (($past(start_lvl) > $past(max_lvl)) ? $past(max_lvl) : $past(start_lvl)));

  assert_no_reenter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && fan_on) |=> (fan_on -> st == S_RUN));

endmodule

// File: tb/sim_fan_drive_seq.sv
module sim_fan_drive_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] req_lvl = 0, start_lvl = 0, min_lvl = 0, max_lvl = 0;
  logic [7:0] boost_ticks = 0;
  logic tick = 0;
  logic [7:0] drive;
  logic fan_on;

  int checks = 0, errors = 0;
  int m_st = 0, m_cnt = 0, m_drv = 0, m_on = 0;

  always #4 clk = ~clk;

  fan_drive_seq u0 (.clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .start_lvl(start_lvl),
    .min_lvl(min_lvl), .max_lvl(max_lvl), .boost_ticks(boost_ticks), .tick(tick),
    .drive(drive), .fan_on(fan_on));

  function automatic int boost_of(int s, int mx);
    return (s > mx) ? mx : s;
  endfunction

  function automatic int run_of(int r, int mn, int mx);
    int v = (r < mn) ? mn : r;
    return (v > mx) ? mx : v;
  endfunction

  task automatic model_edge();
    int r = req_lvl, mn = min_lvl, mx = max_lvl;
    if (!(r != 0 && r >= mn)) begin
      m_st = 0; m_cnt = 0; m_drv = 0; m_on = 0;
    end else begin
      m_on = 1;
      if (m_st == 0) begin
        m_st = 1; m_cnt = 0; m_drv = boost_of(start_lvl, mx);
      end else if (m_st == 1) begin
        if (m_cnt >= int'(boost_ticks)) begin
          m_st = 2; m_drv = run_of(r, mn, mx);
        end else begin
          m_drv = boost_of(start_lvl, mx);
          if (tick) m_cnt++;
        end
      end else m_drv = run_of(r, mn, mx);
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (int'(drive) != m_drv || int'(fan_on) != m_on) begin
      errors++;
      $display("FAIL %s: drive=%0d fan_on=%0d expected drive=%0d fan_on=%0d",
               tag, drive, fan_on, m_drv, m_on);
    end
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic setlv(int r, int s, int mn, int mx, int n);
    req_lvl = 8'(r); start_lvl = 8'(s); min_lvl = 8'(mn); max_lvl = 8'(mx); boost_ticks = 8'(n);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset");

    setlv(100, 200, 40, 180, 2);
    tick = 0;
    step("R3 boost entry capped R7");
    step("R4 boost hold no tick");
    tick = 1;
    step("R4 tick 1");
    step("R4 tick 2");
    tick = 0;
    step("R4 switch to run R5");
    setlv(250, 200, 40, 180, 2);
    step("R5 clamp to max R8");
    setlv(30, 200, 40, 180, 2);
    step("R2 below min drops");
    setlv(0, 0, 0, 180, 0);
    step("R2 zero request with zero min");

    setlv(60, 50, 40, 180, 0);
    step("R3 boost entry R7 uncapped");
    step("R4 zero length boost");
    setlv(90, 50, 120, 80, 0);
    step("R2 crossed bounds below min");
    setlv(150, 50, 120, 80, 0);
    step("R3 entry crossed bounds");
    step("R6 max wins over min");
    setlv(150, 50, 120, 60, 0);
    step("R8 max change next edge");

    for (int i = 0; i < 3000; i++) begin
      int mn = $urandom_range(0, 120);
      int mx = $urandom_range(0, 255);
      int r = ($urandom_range(0, 9) < 8) ? $urandom_range(mn, 255) : $urandom_range(0, mn);
      setlv(r, $urandom_range(0, 255), mn, mx, $urandom_range(0, 5));
      for (int k = 0; k < int'($urandom_range(1, 6)); k++) begin
        tick = ($urandom_range(0, 2) == 0);
        step("R5 R4 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule